// File: doc/BRIEF.md
# Program-Space Table Write Latch Unit

This block sits on the table-access path between a CPU and a 24-bit-wide program memory. The CPU presents a page value and a 16-bit effective address, a space select (low or high 16-bit view of each 24-bit word), a word/byte flag, 16 bits of source data and read/write strobes. Table writes never touch the memory array. They fill one row of holding latches, 32 latches of 24 bits by default. Every table write also records the address it used in a pair of programming-address registers. A separate commit strobe copies the whole latch row into the array row that those registers point at.

Each 24-bit word appears as two 16-bit spaces that share one address. The low space covers bits 15:0. The high space covers bits 23:16 plus an upper byte that does not exist: that byte reads as zero and ignores writes. Table reads return the stored array word, never the latches. The array is a plain register model with a few rows, and it is indexed by the low address bits only.

Top module: `tbl_write_unit`

## Requirements
- R1: A table read with `tbl_rd` high returns data from the array word selected by bits 7:1 of the 16-bit effective address (row in bits 7:6, word in bits 5:1). The page and the higher address bits do not select the word. A low-space word-mode read returns bits 15:0 of that word.
- R2: A high-space word-mode read, or a high-space byte read with address bit 0 clear, returns bits 23:16 of the word in result bits 7:0, with result bits 15:8 zero. A high-space byte read with address bit 0 set addresses the phantom byte and returns 0x0000.
- R3: A high-space word-mode write updates only latch bits 23:16, taking them from source bits 7:0. A high-space byte write with address bit 0 set changes no latch bits.
- R4: In byte mode, address bit 0 picks the byte within the 16-bit space: 0 gives the lower byte and 1 gives the upper byte. Byte reads are zero-extended to 16 bits. In word mode, address bit 0 has no effect on either reads or writes.
- R5: A byte-mode write stores source bits 7:0 into the selected byte, whatever source bits 15:8 hold.
- R6: A table write updates the latch numbered by address bits 5:1. Latches may be written in any order. The write sets bit n of `latch_written`, where n is that latch number, on the next clock.
- R7: A table write does not change the array. A read of the addressed word before a commit returns the old array contents.
- R8: Every table write loads `adr_hi` with the page and `adr_lo` with the effective address on the next clock.
- R9: `adr_wr` loads `adr_hi`/`adr_lo` from `adr_hi_in`/`adr_lo_in`. When `tbl_wr` is high in the same cycle, the table write's address is captured instead.
- R10: `row_commit` copies all latches into the array row given by `adr_lo` bits 7:6 and clears `latch_written`. Latch contents are kept, so a latch that is not rewritten carries its old value into the next commit. A table write in the commit cycle is not part of the committed row, and its flag is set after the clear.
- R11: A read result appears on `tbl_rdata` one clock after `tbl_rd` and holds until the next read. Reads change no latch, flag or address register.
- R12: After reset, `tbl_rdata`, both address registers, all flags, all latches and the whole array are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_page | input | 8 | Page bits, upper part of the 24-bit program address |
| tbl_ea | input | 16 | Effective address, lower part of the program address |
| sel_high | input | 1 | 1 = high space (bits 23:16 + phantom byte), 0 = low space (bits 15:0) |
| byte_mode | input | 1 | 1 = byte access, 0 = word access |
| tbl_wdata | input | 16 | Source data of a table write |
| tbl_wr | input | 1 | Table write strobe |
| tbl_rd | input | 1 | Table read strobe |
| adr_wr | input | 1 | Direct write of the programming-address registers |
| adr_hi_in | input | 8 | Value for `adr_hi` on a direct write |
| adr_lo_in | input | 16 | Value for `adr_lo` on a direct write |
| row_commit | input | 1 | Copy the latch row into the addressed array row |
| tbl_rdata | output | 16 | Registered table read result |
| adr_hi | output | 8 | Upper programming-address register |
| adr_lo | output | 16 | Lower programming-address register |
| latch_written | output | 32 | Per-latch flag: written since the last commit |

## Verification
The hardest situation to reach is a latch that keeps a stale value across commits. To show it, the stimulus fills a full row and commits it. It then rewrites only a few lanes of one latch, including a write aimed at the phantom byte. It redirects the address registers with a direct write and commits again into a different row. Reads then show the new lanes, the untouched lanes and the older neighbours side by side. A second hard case is a commit and a table write in the same clock. The stimulus lines these up deliberately, then reads back to show that the same-cycle write missed the committed row while its flag survived the clear.

// File: rtl/tbl_pkg.sv
package tbl_pkg;

   localparam int WORD_W  = 24;
   localparam int LANE_W  = 8;
   localparam int LANES   = WORD_W / LANE_W;
   localparam int SPACE_W = 16;

   typedef logic [LANES-1:0]   lane_mask_t;
   typedef logic [WORD_W-1:0]  pword_t;
   typedef logic [SPACE_W-1:0] sword_t;

   typedef struct packed {
      lane_mask_t mask;
      pword_t     data;
   } wr_req_t;

   // Aligns source data onto the three byte lanes and picks the lanes to update.
   function automatic wr_req_t build_write(logic hi_space, logic byte_acc,
                                           logic ea_lsb, sword_t src);
      wr_req_t r;
      r.data = {src[7:0], (byte_acc ? src[7:0] : src[15:8]), src[7:0]};
      case ({hi_space, byte_acc})
         2'b00:   r.mask = 3'b011;
         2'b01:   r.mask = ea_lsb ? 3'b010 : 3'b001;
         2'b10:   r.mask = 3'b100;
         default: r.mask = ea_lsb ? 3'b000 : 3'b100;
      endcase
      return r;
   endfunction

   // Selects the 16-bit view of a stored word; the phantom byte reads as zero.
   function automatic sword_t pick_read(pword_t w, logic hi_space,
                                        logic byte_acc, logic ea_lsb);
      sword_t r;
      case ({hi_space, byte_acc})
         2'b00:   r = w[15:0];
         2'b01:   r = ea_lsb ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
         2'b10:   r = {8'h00, w[23:16]};
         default: r = ea_lsb ? 16'h0000 : {8'h00, w[23:16]};
      endcase
      return r;
   endfunction

endpackage

// File: rtl/tbl_addr_capture.sv
module tbl_addr_capture #(
   parameter int PAGE_W = 8,
   parameter int EA_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [PAGE_W-1:0] cap_page,
   input  logic [EA_W-1:0]   cap_ea,
   input  logic              load_en,
   input  logic [PAGE_W-1:0] load_hi,
   input  logic [EA_W-1:0]   load_lo,
   output logic [PAGE_W-1:0] adr_hi,
   output logic [EA_W-1:0]   adr_lo
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adr_hi <= '0;
         adr_lo <= '0;
      end else if (cap_en) begin
         adr_hi <= cap_page;
         adr_lo <= cap_ea;
      end else if (load_en) begin
         adr_hi <= load_hi;
         adr_lo <= load_lo;
      end
   end

endmodule

// File: rtl/tbl_latch_row.sv
module tbl_latch_row
   import tbl_pkg::*;
#(
   parameter int ROW_WORDS = 32,
   localparam int IDX_W    = $clog2(ROW_WORDS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_idx,
   input  lane_mask_t                  wr_mask,
   input  pword_t                      wr_data,
   input  logic                        clr_flags,
   output logic [ROW_WORDS*WORD_W-1:0] row_flat,
   output logic [ROW_WORDS-1:0]        written
);

   for (genvar i = 0; i < ROW_WORDS; i++) begin : g_latch
      logic hit;
      logic flag_q;
      assign hit = wr_en && (wr_idx == IDX_W'(i));

      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [LANE_W-1:0] lane_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lane_q <= '0;
            else if (hit && wr_mask[l])
               lane_q <= wr_data[l*LANE_W +: LANE_W];
         end
         assign row_flat[i*WORD_W + l*LANE_W +: LANE_W] = lane_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flag_q <= 1'b0;
         else if (hit)
            flag_q <= 1'b1;
         else if (clr_flags)
            flag_q <= 1'b0;
      end
      assign written[i] = flag_q;
   end

endmodule

// File: rtl/tbl_store.sv
module tbl_store
   import tbl_pkg::*;
#(
   parameter int ROW_WORDS  = 32,
   parameter int ROWS       = 4,
   localparam int IDX_W     = $clog2(ROW_WORDS),
   localparam int ROW_SEL_W = $clog2(ROWS),
   localparam int WIDX_W    = IDX_W + ROW_SEL_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rd_en,
   input  logic [WIDX_W-1:0]           rd_widx,
   input  logic                        rd_hi,
   input  logic                        rd_byte,
   input  logic                        rd_lsb,
   input  logic                        commit_en,
   input  logic [ROW_SEL_W-1:0]        commit_row,
   input  logic [ROW_WORDS*WORD_W-1:0] row_flat,
   output sword_t                      rdata
);

   logic [ROWS*ROW_WORDS*WORD_W-1:0] mem_flat;
   pword_t                           rd_word;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic row_hit;
      assign row_hit = commit_en && (commit_row == ROW_SEL_W'(r));
      for (genvar w = 0; w < ROW_WORDS; w++) begin : g_word
         pword_t cell_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cell_q <= '0;
            else if (row_hit)
               cell_q <= row_flat[w*WORD_W +: WORD_W];
         end
         assign mem_flat[(r*ROW_WORDS + w)*WORD_W +: WORD_W] = cell_q;
      end
   end

   assign rd_word = mem_flat[rd_widx*WORD_W +: WORD_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_en)
         rdata <= pick_read(rd_word, rd_hi, rd_byte, rd_lsb);
   end

endmodule

// File: rtl/tbl_write_unit.sv
module tbl_write_unit
   import tbl_pkg::*;
#(
   parameter int PAGE_W    = 8,
   parameter int EA_W      = 16,
   parameter int ROW_WORDS = 32,
   parameter int ROWS      = 4,
   localparam int IDX_W     = $clog2(ROW_WORDS),
   localparam int ROW_SEL_W = $clog2(ROWS),
   localparam int WIDX_W    = IDX_W + ROW_SEL_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PAGE_W-1:0]    tbl_page,
   input  logic [EA_W-1:0]      tbl_ea,
   input  logic                 sel_high,
   input  logic                 byte_mode,
   input  logic [SPACE_W-1:0]   tbl_wdata,
   input  logic                 tbl_wr,
   input  logic                 tbl_rd,
   input  logic                 adr_wr,
   input  logic [PAGE_W-1:0]    adr_hi_in,
   input  logic [EA_W-1:0]      adr_lo_in,
   input  logic                 row_commit,
   output logic [SPACE_W-1:0]   tbl_rdata,
   output logic [PAGE_W-1:0]    adr_hi,
   output logic [EA_W-1:0]      adr_lo,
   output logic [ROW_WORDS-1:0] latch_written
);

   initial begin
      assert (ROW_WORDS == (1 << IDX_W))
         else $error("ROW_WORDS must be a power of two");
      assert (ROWS >= 2 && ROWS == (1 << ROW_SEL_W))
         else $error("ROWS must be a power of two, at least 2");
      assert (EA_W > WIDX_W)
         else $error("EA_W too narrow for the array index");
      assert (PAGE_W >= 1)
         else $error("PAGE_W must be positive");
   end

   wr_req_t                     wreq;
   logic [ROW_WORDS*WORD_W-1:0] row_flat;

   assign wreq = build_write(sel_high, byte_mode, tbl_ea[0], tbl_wdata);

   tbl_addr_capture #(.PAGE_W(PAGE_W), .EA_W(EA_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (tbl_wr),
      .cap_page (tbl_page),
      .cap_ea   (tbl_ea),
      .load_en  (adr_wr),
      .load_hi  (adr_hi_in),
      .load_lo  (adr_lo_in),
      .adr_hi   (adr_hi),
      .adr_lo   (adr_lo)
   );

   tbl_latch_row #(.ROW_WORDS(ROW_WORDS)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (tbl_wr),
      .wr_idx    (tbl_ea[IDX_W:1]),
      .wr_mask   (wreq.mask),
      .wr_data   (wreq.data),
      .clr_flags (row_commit),
      .row_flat  (row_flat),
      .written   (latch_written)
   );

   tbl_store #(.ROW_WORDS(ROW_WORDS), .ROWS(ROWS)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (tbl_rd),
      .rd_widx    (tbl_ea[WIDX_W:1]),
      .rd_hi      (sel_high),
      .rd_byte    (byte_mode),
      .rd_lsb     (tbl_ea[0]),
      .commit_en  (row_commit),
      .commit_row (adr_lo[WIDX_W:IDX_W+1]),
      .row_flat   (row_flat),
      .rdata      (tbl_rdata)
   );

endmodule

// File: rtl/tbl_write_unit_chk.sv
module tbl_write_unit_chk #(
   parameter int PAGE_W    = 8,
   parameter int EA_W      = 16,
   parameter int ROW_WORDS = 32,
   localparam int IDX_W    = $clog2(ROW_WORDS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [PAGE_W-1:0]    tbl_page,
   input logic [EA_W-1:0]      tbl_ea,
   input logic                 sel_high,
   input logic                 byte_mode,
   input logic                 tbl_wr,
   input logic                 tbl_rd,
   input logic                 adr_wr,
   input logic [PAGE_W-1:0]    adr_hi_in,
   input logic [EA_W-1:0]      adr_lo_in,
   input logic                 row_commit,
   input logic [15:0]          tbl_rdata,
   input logic [PAGE_W-1:0]    adr_hi,
   input logic [EA_W-1:0]      adr_lo,
   input logic [ROW_WORDS-1:0] latch_written
);

   a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_wr |=> (adr_hi == $past(tbl_page) && adr_lo == $past(tbl_ea)));

   a_r9_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
      (adr_wr && !tbl_wr) |=> (adr_hi == $past(adr_hi_in) && adr_lo == $past(adr_lo_in)));

   a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_wr |=> latch_written[$past(tbl_ea[IDX_W:1])]);

   a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !row_commit |=> ((latch_written & $past(latch_written)) == $past(latch_written)));

   a_r10_commit_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (row_commit && !tbl_wr) |=> (latch_written == '0));

   a_r2_phantom_read: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_rd && sel_high && byte_mode && tbl_ea[0]) |=> (tbl_rdata == 16'h0000));

   a_r4_zero_extend: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_rd && (sel_high || byte_mode)) |=> (tbl_rdata[15:8] == 8'h00));

   a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tbl_rd |=> $stable(tbl_rdata));

   a_r11_read_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_rd && !tbl_wr && !adr_wr && !row_commit) |=>
         ($stable(adr_hi) && $stable(adr_lo) && $stable(latch_written)));

endmodule

bind tbl_write_unit tbl_write_unit_chk #(
   .PAGE_W(PAGE_W), .EA_W(EA_W), .ROW_WORDS(ROW_WORDS)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tbl_page      (tbl_page),
   .tbl_ea        (tbl_ea),
   .sel_high      (sel_high),
   .byte_mode     (byte_mode),
   .tbl_wr        (tbl_wr),
   .tbl_rd        (tbl_rd),
   .adr_wr        (adr_wr),
   .adr_hi_in     (adr_hi_in),
   .adr_lo_in     (adr_lo_in),
   .row_commit    (row_commit),
   .tbl_rdata     (tbl_rdata),
   .adr_hi        (adr_hi),
   .adr_lo        (adr_lo),
   .latch_written (latch_written)
);

// File: tb/tbl_write_unit_tb.sv
module tbl_write_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  tbl_page = '0;
   logic [15:0] tbl_ea = '0;
   logic        sel_high = 1'b0;
   logic        byte_mode = 1'b0;
   logic [15:0] tbl_wdata = '0;
   logic        tbl_wr = 1'b0;
   logic        tbl_rd = 1'b0;
   logic        adr_wr = 1'b0;
   logic [7:0]  adr_hi_in = '0;
   logic [15:0] adr_lo_in = '0;
   logic        row_commit = 1'b0;
   logic [15:0] tbl_rdata;
   logic [7:0]  adr_hi;
   logic [15:0] adr_lo;
   logic [31:0] latch_written;

   always #4 clk = ~clk;

   tbl_write_unit u_dut (
      .clk(clk), .rst_n(rst_n), .tbl_page(tbl_page), .tbl_ea(tbl_ea),
      .sel_high(sel_high), .byte_mode(byte_mode), .tbl_wdata(tbl_wdata),
      .tbl_wr(tbl_wr), .tbl_rd(tbl_rd), .adr_wr(adr_wr), .adr_hi_in(adr_hi_in),
      .adr_lo_in(adr_lo_in), .row_commit(row_commit), .tbl_rdata(tbl_rdata),
      .adr_hi(adr_hi), .adr_lo(adr_lo), .latch_written(latch_written)
   );

   // Reference model state
   logic [23:0] mem_m [128];
   logic [23:0] lat_m [32];
   logic [31:0] flg_m;
   logic [7:0]  ah_m;
   logic [15:0] al_m;
   logic [15:0] rd_m;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // One clock: model update from the pre-edge inputs, then compare mid-cycle.
   task automatic step(input string tag);
      logic [23:0] w;
      int li;
      int ri;
      @(posedge clk);
      if (tbl_rd) begin
         w = mem_m[int'(tbl_ea[7:1])];
         if (!sel_high && !byte_mode)      rd_m = w[15:0];
         else if (!sel_high)               rd_m = tbl_ea[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
         else if (byte_mode && tbl_ea[0])  rd_m = 16'h0000;
         else                              rd_m = {8'h00, w[23:16]};
      end
      if (row_commit) begin
         ri = int'(al_m[7:6]);
         for (int k = 0; k < 32; k++) mem_m[ri*32 + k] = lat_m[k];
         flg_m = '0;
      end
      if (tbl_wr) begin
         li = int'(tbl_ea[5:1]);
         if (!sel_high && !byte_mode) lat_m[li][15:0] = tbl_wdata;
         else if (!sel_high && !tbl_ea[0]) lat_m[li][7:0] = tbl_wdata[7:0];
         else if (!sel_high) lat_m[li][15:8] = tbl_wdata[7:0];
         else if (!byte_mode || !tbl_ea[0]) lat_m[li][23:16] = tbl_wdata[7:0];
         flg_m[li] = 1'b1;
         ah_m = tbl_page;
         al_m = tbl_ea;
      end else if (adr_wr) begin
         ah_m = adr_hi_in;
         al_m = adr_lo_in;
      end
      #2;
      chk({tag, " rdata"}, 32'(tbl_rdata), 32'(rd_m));
      chk({tag, " adr_hi"}, 32'(adr_hi), 32'(ah_m));
      chk({tag, " adr_lo"}, 32'(adr_lo), 32'(al_m));
      chk({tag, " flags"}, latch_written, flg_m);
      tbl_wr = 1'b0; tbl_rd = 1'b0; adr_wr = 1'b0; row_commit = 1'b0;
   endtask

   task automatic twrite(input string tag, input logic [7:0] pg, input logic [15:0] ea,
                         input logic hs, input logic bm, input logic [15:0] d);
      tbl_page = pg; tbl_ea = ea; sel_high = hs; byte_mode = bm; tbl_wdata = d; tbl_wr = 1'b1;
      step(tag);
   endtask

   task automatic tread(input string tag, input logic [15:0] ea, input logic hs,
                        input logic bm, input logic [15:0] exp);
      tbl_page = 8'hC3; tbl_ea = ea; sel_high = hs; byte_mode = bm; tbl_rd = 1'b1;
      step(tag);
      chk({tag, " explicit"}, 32'(tbl_rdata), 32'(exp));
   endtask

   task automatic commit(input string tag);
      row_commit = 1'b1;
      step(tag);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R11 watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 128; k++) mem_m[k] = '0;
      for (int k = 0; k < 32; k++) lat_m[k] = '0;
      flg_m = '0; ah_m = '0; al_m = '0; rd_m = '0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R12: reset state
      chk("R12 rdata", 32'(tbl_rdata), 32'h0);
      chk("R12 adr_hi", 32'(adr_hi), 32'h0);
      chk("R12 adr_lo", 32'(adr_lo), 32'h0);
      chk("R12 flags", latch_written, 32'h0);
      tread("R12 array zero", 16'h0000, 1'b0, 1'b0, 16'h0000);

      // R6: fill row 1 in reverse order, high writes carry junk in bits 15:8 (R3)
      for (int k = 31; k >= 0; k--) begin
         twrite("R6 lo fill", 8'h5A, 16'h3040 | 16'(k << 1), 1'b0, 1'b0, 16'hA000 + 16'(k * 16'h0101));
         twrite("R3 hi fill", 8'h5A, 16'h3040 | 16'(k << 1), 1'b1, 1'b0, {8'hEE, 8'(8'h30 + k)});
      end
      chk("R6 all flags", latch_written, 32'hFFFF_FFFF);
      chk("R8 adr_hi", 32'(adr_hi), 32'h5A);
      chk("R8 adr_lo", 32'(adr_lo), 32'h3040);
      // R7: latches not visible before commit
      tread("R7 no direct write", 16'h004A, 1'b0, 1'b0, 16'h0000);

      commit("R10 commit row1");
      chk("R10 flags cleared", latch_written, 32'h0);

      // R1/R2/R4 reads
      tread("R1 lo word", 16'h004A, 1'b0, 1'b0, 16'hA505);
      tread("R1 alias page+upper", 16'hF04A, 1'b0, 1'b0, 16'hA505);
      tread("R2 hi word", 16'h004A, 1'b1, 1'b0, 16'h0035);
      tread("R4 word ignores lsb", 16'h004B, 1'b0, 1'b0, 16'hA505);
      tread("R4 lo byte0", 16'h004A, 1'b0, 1'b1, 16'h0005);
      tread("R4 lo byte1", 16'h004B, 1'b0, 1'b1, 16'h00A5);
      tread("R2 hi byte0", 16'h004A, 1'b1, 1'b1, 16'h0035);
      tread("R2 phantom read", 16'h004B, 1'b1, 1'b1, 16'h0000);
      // R11: idle cycle holds rdata
      step("R11 hold");
      chk("R11 rdata held", 32'(tbl_rdata), 32'h0);
      tread("R11 read again", 16'h007E, 1'b0, 1'b0, 16'hBF1F);
      step("R11 hold2");
      chk("R11 rdata held2", 32'(tbl_rdata), 32'hBF1F);

      // R5/R3 partial writes to latch 3 and latch 4
      twrite("R5 byte0", 8'h11, 16'h0006, 1'b0, 1'b1, 16'hFF12);
      twrite("R5 byte1", 8'h11, 16'h0007, 1'b0, 1'b1, 16'h7734);
      twrite("R5 hi byte", 8'h11, 16'h0006, 1'b1, 1'b1, 16'h9956);
      twrite("R3 phantom write", 8'h11, 16'h0007, 1'b1, 1'b1, 16'hABCD);
      twrite("R3 hi word", 8'h11, 16'h0008, 1'b1, 1'b0, 16'hC378);
      chk("R6 flags 3,4", latch_written, 32'h0000_0018);
      // R9: direct address load to row 2
      adr_wr = 1'b1; adr_hi_in = 8'h00; adr_lo_in = 16'h0080;
      step("R9 direct");
      chk("R9 adr_lo direct", 32'(adr_lo), 32'h0080);
      commit("R10 commit row2");
      tread("R5 byte lanes", 16'h0086, 1'b0, 1'b0, 16'h3412);
      tread("R3 phantom no effect", 16'h0086, 1'b1, 1'b0, 16'h0056);
      tread("R3 hi word lane", 16'h0088, 1'b1, 1'b0, 16'h0078);
      tread("R10 retained lo", 16'h0088, 1'b0, 1'b0, 16'hA404);
      tread("R10 retained latch0", 16'h0080, 1'b0, 1'b0, 16'hA000);
      tread("R7 row1 intact", 16'h0046, 1'b0, 1'b0, 16'hA303);

      // R9: table write wins over direct load
      adr_wr = 1'b1; adr_hi_in = 8'h77; adr_lo_in = 16'h00C0;
      twrite("R9 priority", 8'h22, 16'h0010, 1'b0, 1'b0, 16'h1111);
      chk("R9 wr wins hi", 32'(adr_hi), 32'h22);
      chk("R9 wr wins lo", 32'(adr_lo), 32'h0010);

      // R10: commit with same-cycle write (row 0 from adr_lo 0x0010)
      row_commit = 1'b1;
      twrite("R10 commit+write", 8'h22, 16'h0012, 1'b0, 1'b0, 16'h2222);
      chk("R10 flag after clear", latch_written, 32'h0000_0200);
      tread("R10 same-cycle write excluded", 16'h0012, 1'b0, 1'b0, 16'hA909);
      tread("R10 earlier write included", 16'h0010, 1'b0, 1'b0, 16'h1111);
      tread("R1 untouched row3", 16'h00C4, 1'b0, 1'b0, 16'h0000);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule